// File: doc/BRIEF.md
# Dual-Role SPI Serial Port

This block is a byte-wide serial port that works either as the clock-owning master or as a clocked slave on an SPI bus. Bytes shift most significant bit first. Each transfer sends one byte and receives one byte at the same time. The bus clock idles low. Incoming data is captured on the rising clock edge, and outgoing data changes after the falling edge.

In master role the port makes the serial clock itself, as a programmable divide of the system clock. In slave role it samples the external clock and the enable pin through a two-flop synchronizer. It then finds clock edges in the system clock domain.

An optional enable pin can be switched on. In 4-pin mode this pin lets several masters share a bus, because a master releases its clock and data drivers while the pin is low. For a slave, the same pin selects the device and gates its data output. A soft-reset bit comes up set after power-on and holds the port idle, and while it is set it forces all of the status and interrupt-enable flags to known values.

The engine is one state machine with four states:
- IDLE: no transfer.
- MLOW: master, clock low half.
- MHIGH: master, clock high half.
- SACT: slave, selected.

Its transitions are:
- IDLE to MLOW when the master is allowed and a byte is pending.
- IDLE to SACT when the slave is selected.
- MLOW to MHIGH at the end of a half period.
- MHIGH to MLOW at the end of a half period when bits remain.
- MHIGH to IDLE after the eighth bit.
- MLOW or MHIGH to IDLE on abort, that is reset, role change, or the enable pin going low in 4-pin mode.
- SACT to IDLE when deselected.

Top module: `spi_dual_port`

## Requirements
- R1: After rst_n the control register (address 0) reads 0x01, which means only the soft-reset bit (bit 0) is set. The status register (address 1) reads 0x02, which means only transmit-empty is set. sclk_oe, mosi_oe and miso_oe are all 0.
- R2: Control bits are: bit 0 soft reset, bit 1 master role, bit 2 4-pin mode, bit 3 module enable, bit 4 receive interrupt enable, bit 5 transmit interrupt enable. With master role and module enable set, and the enable pin allowing it, sclk_oe and mosi_oe are 1 and miso_oe is 0.
- R3: In slave role sclk_oe and mosi_oe are 0. miso_oe is 1 only when the module is enabled and either 3-pin mode is selected or ste_in is low.
- R4: In 3-pin mode ste_in has no effect. In 4-pin master mode, ste_in low forces sclk_oe and mosi_oe to 0, and a pending byte does not start a transfer; the transmit-empty flag stays clear.
- R5: A write to the data register (address 2) in master role, enabled and out of soft reset, produces exactly 8 sclk_out pulses. Each high phase lasts DIV+1 system clocks, where DIV is the register at address 3. mosi_out carries the byte MSB first and is valid at each rising edge. The byte sampled on miso_in at the rising edges is then read from the data register.
- R6: A selected slave captures mosi_in on the rising edges of sclk_in, MSB first. It presents the byte written to its data register on miso_out, starting with the MSB before the first rising edge. After 8 bits, receive-ready (status bit 0) is set and the byte reads from the data register.
- R7: A 4-pin slave with ste_in high ignores sclk_in edges and receives nothing.
- R8: When a byte completes while receive-ready is still set, the overrun flag (status bit 2) is set and the data register holds the newer byte.
- R9: While soft reset is set:
  - receive-ready, overrun, the framing error flag and both interrupt enables are cleared;
  - transmit-empty is set;
  - data register writes are ignored;
  - the module enable bit is kept.
- R10: In 4-pin mode, the enable pin going inactive in the middle of a byte aborts the transfer and sets the framing error flag (status bit 3). Writing 1 to status bit 3 clears it.
- R11: irq_rx equals receive-ready AND the receive interrupt enable, and irq_tx equals transmit-empty AND the transmit interrupt enable.
- R12: A data register write clears transmit-empty (status bit 1). Transmit-empty is set again when the byte moves into the shift register. A data register read clears receive-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| sclk_in | input | 1 | Serial clock from pad |
| sclk_out | output | 1 | Serial clock to pad |
| sclk_oe | output | 1 | Serial clock driver enable |
| mosi_in | input | 1 | Master-out/slave-in from pad |
| mosi_out | output | 1 | Master-out/slave-in to pad |
| mosi_oe | output | 1 | Master-out/slave-in driver enable |
| miso_in | input | 1 | Slave-out/master-in from pad |
| miso_out | output | 1 | Slave-out/master-in to pad |
| miso_oe | output | 1 | Slave-out/master-in driver enable |
| ste_in | input | 1 | Transmit-enable pin |

## Verification
Some properties are checked on every cycle:
- The master states are reached only from master role and the slave state only from slave role.
- The two sets of pad drivers are never both enabled.
- A completed byte that finds receive-ready still set always leaves overrun set.
- Soft reset always leaves the flags at their forced values.
- A framing abort always sets the error flag.
- A byte moved into the shift register always sets transmit-empty.

Only the bench scenarios can show the serial behaviour: bit order, the high-phase length for several divisors, and slave timing against an external clock. The same holds for the pin gating by the enable pin and the abort in the middle of a byte.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MLOW  = 2'd1,
        ST_MHIGH = 2'd2,
        ST_SACT  = 2'd3
    } eng_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int C_SWRST  = 0;
    localparam int C_MASTER = 1;
    localparam int C_FOUR   = 2;
    localparam int C_EN     = 3;
    localparam int C_RXIE   = 4;
    localparam int C_TXIE   = 5;

    localparam int S_RXRDY  = 0;
    localparam int S_TXEMP  = 1;
    localparam int S_OVR    = 2;
    localparam int S_FERR   = 3;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_dual_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              master,
    input  logic              four_pin,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ste_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              miso_in,
    output logic              tx_take,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              frame_err,
    output logic              sclk_out,
    output logic              ser_out
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    eng_state_t        state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [DIV_W-1:0]  divcnt;
    logic              samp;
    logic              sclk_d;

    logic sclk_rise, sclk_fall, half_done, last_bit, m_ok, s_sel, in_master;
    logic [DATA_W-1:0] shifted;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign half_done = (divcnt == div);
    assign last_bit  = (bitcnt == LAST);
    assign m_ok      = run & master & (~four_pin | ste_s);
    assign s_sel     = run & ~master & (~four_pin | ~ste_s);
    assign shifted   = {shreg[DATA_W-2:0], samp};
    assign in_master = (state == ST_MLOW) || (state == ST_MHIGH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (m_ok && tx_valid) nxt = ST_MLOW;
                else if (s_sel)       nxt = ST_SACT;
            end
            ST_MLOW: begin
                if (!m_ok)          nxt = ST_IDLE;
                else if (half_done) nxt = ST_MHIGH;
            end
            ST_MHIGH: begin
                if (!m_ok)                      nxt = ST_IDLE;
                else if (half_done && last_bit) nxt = ST_IDLE;
                else if (half_done)             nxt = ST_MLOW;
            end
            ST_SACT: begin
                if (!s_sel) nxt = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        tx_take   = 1'b0;
        rx_done   = 1'b0;
        frame_err = 1'b0;
        sclk_out  = 1'b0;
        unique case (state)
            ST_IDLE: tx_take = m_ok & tx_valid;
            ST_MLOW: frame_err = run & master & four_pin & ~ste_s;
            ST_MHIGH: begin
                sclk_out  = 1'b1;
                frame_err = run & master & four_pin & ~ste_s;
                rx_done   = m_ok & half_done & last_bit;
            end
            ST_SACT: begin
                tx_take   = s_sel & tx_valid & (bitcnt == '0) & ~sclk_s & ~sclk_d;
                rx_done   = s_sel & sclk_fall & last_bit;
                frame_err = run & ~master & four_pin & ste_s & (bitcnt != '0);
            end
        endcase
    end

    assign rx_data = shifted;
    assign ser_out = shreg[DATA_W-1];

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            samp   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            unique case (state)
                ST_IDLE: begin
                    divcnt <= '0;
                    bitcnt <= '0;
                    if (tx_take) shreg <= tx_data;
                end
                ST_MLOW: begin
                    if (half_done) begin
                        divcnt <= '0;
                        samp   <= miso_in;
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                ST_MHIGH: begin
                    if (half_done) begin
                        divcnt <= '0;
                        shreg  <= shifted;
                        bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                ST_SACT: begin
                    if (!s_sel) begin
                        bitcnt <= '0;
                    end else if (tx_take) begin
                        shreg <= tx_data;
                    end else if (sclk_rise) begin
                        samp <= mosi_s;
                    end else if (sclk_fall) begin
                        shreg  <= shifted;
                        bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // master states are only ever entered or held from master role (R2)
    p_mclk_role_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_master |-> $past(master));

    // the slave state is only reached from slave role (R6)
    p_slave_role_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SACT) |-> $past(!master));

endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_dual_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              swrst,
    output logic              master,
    output logic              four_pin,
    output logic              mod_en,
    output logic [DIV_W-1:0]  div,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_take,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              frame_err,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic rxie, txie, rx_ready, tx_empty, ovr, ferr;
    logic [DATA_W-1:0] rx_buf;
    logic wr_ctrl, wr_stat, wr_data, wr_div, rd_data;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign wr_div  = reg_wr && (reg_addr == A_DIV);
    assign rd_data = reg_rd && (reg_addr == A_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swrst    <= 1'b1;
            master   <= 1'b0;
            four_pin <= 1'b0;
            mod_en   <= 1'b0;
            rxie     <= 1'b0;
            txie     <= 1'b0;
            rx_ready <= 1'b0;
            tx_empty <= 1'b1;
            ovr      <= 1'b0;
            ferr     <= 1'b0;
            div      <= '0;
            tx_data  <= '0;
            rx_buf   <= '0;
        end else begin
            if (wr_ctrl) begin
                swrst    <= reg_wdata[C_SWRST];
                master   <= reg_wdata[C_MASTER];
                four_pin <= reg_wdata[C_FOUR];
                mod_en   <= reg_wdata[C_EN];
                rxie     <= reg_wdata[C_RXIE];
                txie     <= reg_wdata[C_TXIE];
            end
            if (wr_div) div <= reg_wdata[DIV_W-1:0];
            if (wr_stat) begin
                if (reg_wdata[S_OVR])  ovr  <= 1'b0;
                if (reg_wdata[S_FERR]) ferr <= 1'b0;
            end
            if (frame_err) ferr <= 1'b1;
            if (rd_data) rx_ready <= 1'b0;
            if (rx_done) begin
                rx_buf   <= rx_data;
                rx_ready <= 1'b1;
                if (rx_ready && !rd_data) ovr <= 1'b1;
            end
            if (tx_take) tx_empty <= 1'b1;
            if (wr_data && !swrst) begin
                tx_data  <= reg_wdata[DATA_W-1:0];
                tx_empty <= 1'b0;
            end
            if (swrst) begin
                rxie     <= 1'b0;
                txie     <= 1'b0;
                rx_ready <= 1'b0;
                ovr      <= 1'b0;
                ferr     <= 1'b0;
                tx_empty <= 1'b1;
            end
        end
    end

    assign tx_valid = ~tx_empty;
    assign irq_rx   = rx_ready & rxie;
    assign irq_tx   = tx_empty & txie;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_SWRST]  = swrst;
                reg_rdata[C_MASTER] = master;
                reg_rdata[C_FOUR]   = four_pin;
                reg_rdata[C_EN]     = mod_en;
                reg_rdata[C_RXIE]   = rxie;
                reg_rdata[C_TXIE]   = txie;
            end
            A_STAT: begin
                reg_rdata[S_RXRDY] = rx_ready;
                reg_rdata[S_TXEMP] = tx_empty;
                reg_rdata[S_OVR]   = ovr;
                reg_rdata[S_FERR]  = ferr;
            end
            A_DATA: reg_rdata = BUS_W'(rx_buf);
            A_DIV:  reg_rdata = BUS_W'(div);
        endcase
    end

    // unread byte overwritten -> overrun (R8)
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ready && !rd_data) |=> ovr);

    // soft reset forces flag values (R9)
    p_swrst_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (tx_empty && !rx_ready && !ovr && !ferr && !rxie && !txie));

    // enable-pin abort always recorded (R10)
    p_ferr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> ferr);

    // byte moved to the shifter frees the buffer (R12)
    p_take_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !wr_data) |=> tx_empty);

endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
    import spi_dual_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_rx,
    output logic       irq_tx,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       sclk_oe,
    input  logic       mosi_in,
    output logic       mosi_out,
    output logic       mosi_oe,
    input  logic       miso_in,
    output logic       miso_out,
    output logic       miso_oe,
    input  logic       ste_in
);
    localparam int BUS_W = 8;

    logic              swrst, master, four_pin, mod_en, run;
    logic [DIV_W-1:0]  div;
    logic              tx_valid, tx_take, rx_done, frame_err, ser_out;
    logic [DATA_W-1:0] tx_data, rx_data;
    logic [2:0]        pins_s;

    assign run = mod_en & ~swrst;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ste_in, sclk_in, mosi_in}),
        .q     (pins_s)
    );

    spi_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .swrst     (swrst),
        .master    (master),
        .four_pin  (four_pin),
        .mod_en    (mod_en),
        .div       (div),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_take   (tx_take),
        .rx_done   (rx_done),
        .rx_data   (rx_data),
        .frame_err (frame_err),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    spi_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .master    (master),
        .four_pin  (four_pin),
        .div       (div),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .ste_s     (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .miso_in   (miso_in),
        .tx_take   (tx_take),
        .rx_done   (rx_done),
        .rx_data   (rx_data),
        .frame_err (frame_err),
        .sclk_out  (sclk_out),
        .ser_out   (ser_out)
    );

    // pad direction: master drives clock and data-out unless released by
    // the enable pin in 4-pin mode; slave drives data-out only when selected
    assign sclk_oe  = mod_en & master & ~(four_pin & ~ste_in);
    assign mosi_oe  = mod_en & master & ~(four_pin & ~ste_in);
    assign miso_oe  = mod_en & ~master & ~(four_pin & ste_in);
    assign mosi_out = ser_out;
    assign miso_out = ser_out;

    // the two roles never drive the bus together (R3)
    p_oe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(miso_oe && (mosi_oe || sclk_oe)));

endmodule

// File: tb/spi_dual_port_bench.sv
`timescale 1ns/1ps
module spi_dual_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_rx, irq_tx;
    logic       sclk_in = 1'b0, mosi_in = 1'b0, ste_in = 1'b0;
    logic       sclk_out, sclk_oe, mosi_out, mosi_oe, miso_in, miso_out, miso_oe;

    int checks = 0, fails = 0;
    int cyc = 0, t_rise = 0, half = 0, nrise = 0;
    logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    spi_dual_port u_spi_dual_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ste_in(ste_in)
    );

    // remote slave model for master-role tests
    assign miso_in = slv_tx[7];
    always @(posedge sclk_out) begin
        slv_rx = {slv_rx[6:0], mosi_out};
        t_rise = cyc;
        nrise  = nrise + 1;
    end
    always @(negedge sclk_out) begin
        half   = cyc - t_rise;
        slv_tx = {slv_tx[6:0], 1'b0};
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq_rx && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // {master byte, remote reply, divisor}
    localparam logic [23:0] VEC [4] = '{
        {8'hA5, 8'h3C, 8'd0},
        {8'h01, 8'h80, 8'd1},
        {8'hFF, 8'h00, 8'd3},
        {8'h5A, 8'hC3, 8'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        logic [7:0] v, got, m;
        int r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk(v == 8'h01, "R1 ctrl", v, 8'h01);
        rd(2'd1, v); chk(v == 8'h02, "R1 stat", v, 8'h02);
        chk({sclk_oe, mosi_oe, miso_oe} == 3'b000, "R1 oe", {sclk_oe, mosi_oe, miso_oe}, 0);

        // R9 data write ignored while held in soft reset
        wr(2'd0, 8'h0B);
        wr(2'd2, 8'h55);
        rd(2'd1, v); chk(v == 8'h02, "R9 write ignored", v, 8'h02);
        wr(2'd0, 8'h0A);
        wr(2'd0, 8'h3A);
        // R2 master pins; R4 3-pin mode ignores ste_in (held low)
        chk({sclk_oe, mosi_oe, miso_oe} == 3'b110, "R2 R4 master oe", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
        chk(irq_tx == 1'b1, "R11 irq_tx", irq_tx, 1);

        // R5 vector table of master transfers
        for (int i = 0; i < 4; i++) begin
            logic [7:0] tx, rep, dv;
            {tx, rep, dv} = VEC[i];
            wr(2'd3, dv);
            slv_tx = rep; nrise = 0;
            wr(2'd2, tx);
            wait_irq();
            repeat (2) @(negedge clk);
            chk(slv_rx == tx, "R5 mosi byte", slv_rx, tx);
            chk(nrise == 8, "R5 pulse count", nrise, 8);
            chk(half == int'(dv) + 1, "R5 high phase", half, int'(dv) + 1);
            rd(2'd2, v); chk(v == rep, "R5 received byte", v, rep);
            @(negedge clk);
            chk(irq_rx == 1'b0, "R12 read clears ready", irq_rx, 0);
        end
        chk(irq_tx == 1'b1, "R11 irq_tx after transfers", irq_tx, 1);

        // R8 overrun
        wr(2'd3, 8'd0);
        slv_tx = 8'h11;
        wr(2'd2, 8'h22);
        wait_irq();
        repeat (4) @(negedge clk);
        slv_tx = 8'h33;
        wr(2'd2, 8'h44);
        repeat (80) @(negedge clk);
        rd(2'd1, v); chk(v == 8'h07, "R8 overrun flag", v, 8'h07);
        rd(2'd2, v); chk(v == 8'h33, "R8 newer byte kept", v, 8'h33);

        // R9 soft reset clears flags, keeps enable
        wr(2'd0, 8'h3B);
        rd(2'd0, v); chk(v == 8'h0B, "R9 ctrl kept en", v, 8'h0B);
        rd(2'd1, v); chk(v == 8'h02, "R9 flags", v, 8'h02);
        wr(2'd0, 8'h0A);

        // R4 / R10 4-pin master
        ste_in = 1'b1;
        wr(2'd0, 8'h3E);
        wr(2'd3, 8'd3);
        slv_tx = 8'h00;
        wr(2'd2, 8'hC7);
        repeat (20) @(negedge clk);
        ste_in = 1'b0;
        repeat (10) @(negedge clk);
        chk({sclk_oe, mosi_oe} == 2'b00, "R4 released oe", {sclk_oe, mosi_oe}, 0);
        rd(2'd1, v); chk(v == 8'h0A, "R10 framing flag", v, 8'h0A);
        r = nrise;
        wr(2'd2, 8'h3C);
        repeat (100) @(negedge clk);
        chk(nrise == r, "R4 no start", nrise, r);
        rd(2'd1, v); chk(v == 8'h08, "R4 byte pending", v, 8'h08);
        ste_in = 1'b1;
        wait_irq();
        rd(2'd2, v);
        wr(2'd1, 8'h08);
        rd(2'd1, v); chk(v == 8'h02, "R10 clear flag", v, 8'h02);

        // slave, 4-pin
        wr(2'd0, 8'h0D);
        wr(2'd0, 8'h0C);
        wr(2'd0, 8'h3C);
        chk({sclk_oe, mosi_oe, miso_oe} == 3'b000, "R3 deselected oe", {sclk_oe, mosi_oe, miso_oe}, 0);
        for (int k = 0; k < 8; k++) begin
            repeat (6) @(negedge clk); sclk_in = 1'b1;
            repeat (6) @(negedge clk); sclk_in = 1'b0;
        end
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk(v == 8'h02, "R7 edges ignored", v, 8'h02);
        wr(2'd2, 8'h96);
        rd(2'd1, v); chk(v == 8'h00, "R12 write clears empty", v, 8'h00);
        ste_in = 1'b0;
        repeat (8) @(negedge clk);
        chk({sclk_oe, mosi_oe, miso_oe} == 3'b001, "R3 selected oe", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
        m = 8'h6B; got = 8'h00;
        for (int k = 7; k >= 0; k--) begin
            mosi_in = m[k];
            repeat (8) @(negedge clk);
            got = {got[6:0], miso_out};
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (10) @(negedge clk);
        chk(got == 8'h96, "R6 miso byte", got, 8'h96);
        chk(irq_rx == 1'b1, "R11 irq_rx", irq_rx, 1);
        rd(2'd1, v); chk(v == 8'h03, "R6 R12 stat", v, 8'h03);
        rd(2'd2, v); chk(v == 8'h6B, "R6 received byte", v, 8'h6B);
        ste_in = 1'b1;
        repeat (4) @(negedge clk);
        summary();
    end
endmodule